// File: doc/BRIEF.md
# Synchronous Exception Trap Target Selector

This block decides, for a synchronous exception, which privilege level takes the trap and which trap-vector register supplies the handler base. It looks up the exception code in the exception delegation register. A set bit asks for supervisor handling. That request is honoured only when the supervisor level is configured as present. Otherwise the trap goes to machine level.

The chosen level is then clamped so that a trap never lands below the privilege the hart is running at. The block selects the machine or supervisor vector register to match the final level. If the final level is not supervisor or machine, it raises an internal-error flag instead of selecting a vector.

The decision logic is combinational. A parameter adds a result register so that the block can sit on a pipeline boundary. With that register, every output reflects the inputs present at the previous rising clock edge. Cause and return-address updates, vectored-mode offset arithmetic and interrupt dispatch belong to neighbouring logic.

Top module: `trap_target_sel`

## Requirements
- R1: Privilege encoding is user=2'b00, supervisor=2'b01, machine=2'b11; 2'b10 is reserved. With the supervisor level present and the current level user or supervisor, a code whose bit in the delegation register is 1 gives target 2'b01, and a code whose bit is 0 gives target 2'b11.
- R2: When the supervisor-present input is 0, the target is machine (2'b11) whatever the delegation register holds.
- R3: An exception code equal to or larger than the delegation register width (16 by default) gives a machine target, even when every delegation bit is 1. Code 15 is still looked up in the register.
- R4: When the target level is numerically below the current level, the current level is reported instead. For example, current machine with the code delegated gives machine.
- R5: The vector output equals the machine vector input for a machine target and the supervisor vector input for a supervisor target.
- R6: When the final target is neither supervisor nor machine, the internal-error output is 1 and the vector output is zero. The target output still reports the final level. With legal inputs, this happens only for reserved current level 2'b10 combined with a supervisor request. In every other case the internal-error output is 0.
- R7: With the output register enabled (the default), outputs change one clock after the inputs. While the active-low synchronous reset is applied, the target reads 2'b11, the vector reads zero and the error flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Synchronous reset, active low |
| exc_code_i | input | CODE_W (6) | Numeric exception code |
| cur_priv_i | input | 2 | Privilege level the hart is running at |
| deleg_i | input | DELEG_W (16) | Exception delegation register, one bit per code |
| supv_en_i | input | 1 | Supervisor level configured as present |
| mtvec_i | input | XLEN (32) | Machine trap-vector register value |
| stvec_i | input | XLEN (32) | Supervisor trap-vector register value |
| tgt_priv_o | output | 2 | Privilege level that takes the trap |
| tvec_o | output | XLEN (32) | Selected trap-vector register value |
| int_err_o | output | 1 | Internal error: final target is not a trap-taking level |

## Verification
The assertions assume that the current-level input holds one of the four two-bit codes. They also assume that the inputs are stable at the sampling edge. Under those assumptions, any final level below the current one, or any non-machine target with the supervisor level absent, can only come from a design fault. The stimulus sets inputs one half-period away from the active edge and holds them for a full clock. It uses the reserved current level only in the cases that exercise the error flag. It includes codes on both sides of the register-width boundary, so the out-of-range rule is reached on purpose and never by accident.

// File: rtl/trap_sel_pkg.sv
// Shared types for the trap target selector.
// Assumes a two-bit privilege code with one reserved value.
package trap_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_USER = 2'b00,
        PRIV_SUPV = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_MACH = 2'b11
    } priv_e;

endpackage

// File: rtl/deleg_lookup.sv
// Delegation lookup: decides whether an exception asks for supervisor handling.
// Assumes CODE_W is wide enough to index every delegation bit; codes beyond the
// register width never request delegation.
module deleg_lookup #(
    parameter int DELEG_W = 16,
    parameter int CODE_W  = 6
) (
    input  logic [CODE_W-1:0]  code_i,
    input  logic [DELEG_W-1:0] deleg_i,
    input  logic               supv_en_i,
    output logic               want_supv_o
);
    localparam int IDX_W = (DELEG_W > 1) ? $clog2(DELEG_W) : 1;

    logic             in_range;
    logic [IDX_W-1:0] idx;

    generate
        if (CODE_W > IDX_W) begin : g_wide_code
            localparam logic [CODE_W-1:0] LIMIT = CODE_W'(DELEG_W);
            // Flags codes that have a bit in the delegation register.
            always_comb in_range = (code_i < LIMIT);
            // Low code bits select the delegation bit.
            always_comb idx = code_i[IDX_W-1:0];
        end else begin : g_narrow_code
            // Every representable code fits inside the register.
            always_comb in_range = 1'b1;
            // Zero-extend the code to the index width.
            always_comb idx = IDX_W'(code_i);
        end
    endgenerate

    // Supervisor handling is requested only for present, in-range, delegated codes.
    always_comb want_supv_o = supv_en_i && in_range && deleg_i[idx];

endmodule

// File: rtl/priv_clamp.sv
// Privilege clamp: turns the delegation request into a final target level,
// never below the current level, and flags targets that cannot take a trap.
// Assumes the request resolves to supervisor or machine before clamping.
module priv_clamp
    import trap_sel_pkg::*;
(
    input  logic  want_supv_i,
    input  priv_e cur_priv_i,
    output priv_e tgt_priv_o,
    output logic  bad_tgt_o
);
    priv_e req_priv;

    // Requested level before comparing with the running level.
    always_comb req_priv = want_supv_i ? PRIV_SUPV : PRIV_MACH;

    // Keep the running level when the request would demote the trap.
    always_comb tgt_priv_o = (req_priv < cur_priv_i) ? cur_priv_i : req_priv;

    // Only supervisor and machine own a trap vector.
    always_comb bad_tgt_o = !((tgt_priv_o == PRIV_SUPV) || (tgt_priv_o == PRIV_MACH));

endmodule

// File: rtl/vec_select.sv
// Vector select: picks the trap-vector register matching the target level.
// Assumes an invalid target selects nothing; the output is then zero.
module vec_select
    import trap_sel_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  priv_e            tgt_priv_i,
    input  logic             bad_tgt_i,
    input  logic [XLEN-1:0]  mtvec_i,
    input  logic [XLEN-1:0]  stvec_i,
    output logic [XLEN-1:0]  tvec_o
);
    // Route the owning level's vector, or zero on an invalid target.
    always_comb begin
        tvec_o = '0;
        if (!bad_tgt_i) begin
            case (tgt_priv_i)
                PRIV_MACH: tvec_o = mtvec_i;
                PRIV_SUPV: tvec_o = stvec_i;
                default:   tvec_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/trap_target_sel.sv
// Trap target selector top: delegation lookup, privilege clamp and vector
// select, with an optional output register (REG_OUT). Assumes the current
// level input is stable around the active edge; reset is synchronous, active low.
module trap_target_sel
    import trap_sel_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int DELEG_W = 16,
    parameter int CODE_W  = 6,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [CODE_W-1:0]  exc_code_i,
    input  logic [1:0]         cur_priv_i,
    input  logic [DELEG_W-1:0] deleg_i,
    input  logic               supv_en_i,
    input  logic [XLEN-1:0]    mtvec_i,
    input  logic [XLEN-1:0]    stvec_i,
    output logic [1:0]         tgt_priv_o,
    output logic [XLEN-1:0]    tvec_o,
    output logic               int_err_o
);
    localparam logic [CODE_W-1:0] CODE_LIMIT = CODE_W'(DELEG_W);

    logic            want_supv;
    priv_e           cur_priv;
    priv_e           tgt_c;
    logic            err_c;
    logic [XLEN-1:0] vec_c;

    // Interpret the raw level bits as the shared enum.
    always_comb cur_priv = priv_e'(cur_priv_i);

    deleg_lookup #(
        .DELEG_W (DELEG_W),
        .CODE_W  (CODE_W)
    ) lookup_i (
        .code_i      (exc_code_i),
        .deleg_i     (deleg_i),
        .supv_en_i   (supv_en_i),
        .want_supv_o (want_supv)
    );

    priv_clamp clamp_i (
        .want_supv_i (want_supv),
        .cur_priv_i  (cur_priv),
        .tgt_priv_o  (tgt_c),
        .bad_tgt_o   (err_c)
    );

    vec_select #(
        .XLEN (XLEN)
    ) vsel_i (
        .tgt_priv_i (tgt_c),
        .bad_tgt_i  (err_c),
        .mtvec_i    (mtvec_i),
        .stvec_i    (stvec_i),
        .tvec_o     (vec_c)
    );

    generate
        if (REG_OUT) begin : g_reg_out
            logic [1:0]      tgt_q;
            logic [XLEN-1:0] vec_q;
            logic            err_q;
            // Capture the decision each cycle; reset parks on machine, no error.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    tgt_q <= PRIV_MACH;
                    vec_q <= '0;
                    err_q <= 1'b0;
                end else begin
                    tgt_q <= tgt_c;
                    vec_q <= vec_c;
                    err_q <= err_c;
                end
            end
            // Drive the ports from the result register.
            always_comb begin
                tgt_priv_o = tgt_q;
                tvec_o     = vec_q;
                int_err_o  = err_q;
            end
        end else begin : g_comb_out
            // Drive the ports straight from the decision logic.
            always_comb begin
                tgt_priv_o = tgt_c;
                tvec_o     = vec_c;
                int_err_o  = err_c;
            end
        end
    endgenerate

    // R4: a valid target is never below the running level.
    a_r4_no_demote: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err_c |-> (tgt_c >= cur_priv));

    // R2: with no supervisor level every exception goes to machine.
    a_r2_no_supv_machine: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supv_en_i |-> (tgt_c == PRIV_MACH));

    // R3: codes past the register width are never delegated.
    a_r3_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_code_i >= CODE_LIMIT) |-> (tgt_c == PRIV_MACH));

    // R6: an invalid target selects no vector, at the decision point.
    a_r6_err_no_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_c |-> (vec_c == '0));

    // R6: the same holds on the block outputs.
    a_r6_err_port_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_err_o |-> (tvec_o == '0));

    // R1: a supervisor target occurs only when the level is present.
    a_r1_supv_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tgt_c == PRIV_SUPV) |-> supv_en_i);

endmodule

// File: tb/trap_target_sel_tb_top.sv
module trap_target_sel_tb_top;
    localparam int XLEN    = 32;
    localparam int DELEG_W = 16;
    localparam int CODE_W  = 6;
    localparam logic [XLEN-1:0] MVEC = 32'h8000_0100;
    localparam logic [XLEN-1:0] SVEC = 32'h4000_0200;

    // Entry: req(4) code(6) cur(2) supv_en(1) deleg(16) exp_tgt(2) exp_err(1) vsel(2)
    // vsel: 0 = zero, 1 = machine vector, 2 = supervisor vector
    localparam int NV = 13;
    localparam logic [33:0] VEC_TBL [0:NV-1] = '{
        {4'd1, 6'd2,  2'b00, 1'b1, 16'h0104, 2'b01, 1'b0, 2'd2}, // R1 delegated from user
        {4'd1, 6'd8,  2'b01, 1'b1, 16'h0104, 2'b01, 1'b0, 2'd2}, // R1 delegated from supervisor
        {4'd1, 6'd3,  2'b00, 1'b1, 16'h0104, 2'b11, 1'b0, 2'd1}, // R1 bit clear
        {4'd2, 6'd2,  2'b00, 1'b0, 16'h0104, 2'b11, 1'b0, 2'd1}, // R2 supervisor absent
        {4'd2, 6'd8,  2'b01, 1'b0, 16'hFFFF, 2'b11, 1'b0, 2'd1}, // R2 all bits set
        {4'd3, 6'd16, 2'b00, 1'b1, 16'hFFFF, 2'b11, 1'b0, 2'd1}, // R3 first out-of-range
        {4'd3, 6'd63, 2'b01, 1'b1, 16'hFFFF, 2'b11, 1'b0, 2'd1}, // R3 largest code
        {4'd3, 6'd15, 2'b00, 1'b1, 16'hFFFF, 2'b01, 1'b0, 2'd2}, // R3 last in-range
        {4'd4, 6'd2,  2'b11, 1'b1, 16'h0104, 2'b11, 1'b0, 2'd1}, // R4 clamp at machine
        {4'd4, 6'd0,  2'b11, 1'b1, 16'hFFFF, 2'b11, 1'b0, 2'd1}, // R4 clamp, code 0
        {4'd6, 6'd2,  2'b10, 1'b1, 16'h0104, 2'b10, 1'b1, 2'd0}, // R6 invalid target
        {4'd6, 6'd3,  2'b10, 1'b1, 16'h0104, 2'b11, 1'b0, 2'd1}, // R6 reserved but machine
        {4'd5, 6'd0,  2'b01, 1'b1, 16'h0001, 2'b01, 1'b0, 2'd2}  // R5 supervisor vector
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic [1:0]        cur = 2'b00;
    logic [DELEG_W-1:0] deleg = '0;
    logic              supv_en = 1'b0;
    logic [XLEN-1:0]   mtvec = MVEC;
    logic [XLEN-1:0]   stvec = SVEC;
    logic [1:0]        tgt;
    logic [XLEN-1:0]   tvec;
    logic              err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    trap_target_sel #(
        .XLEN (XLEN), .DELEG_W (DELEG_W), .CODE_W (CODE_W), .REG_OUT (1'b1)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .exc_code_i (code), .cur_priv_i (cur),
        .deleg_i (deleg), .supv_en_i (supv_en), .mtvec_i (mtvec), .stvec_i (stvec),
        .tgt_priv_o (tgt), .tvec_o (tvec), .int_err_o (err)
    );

    task automatic check(input string req, input logic [1:0] et, input logic ee,
                         input logic [XLEN-1:0] ev);
        n_checks++;
        if (tgt !== et || err !== ee || tvec !== ev) begin
            n_fail++;
            $display("FAIL %s: got tgt=%b err=%b vec=%h, expected tgt=%b err=%b vec=%h",
                     req, tgt, err, tvec, et, ee, ev);
        end
    endtask

    task automatic apply(input logic [5:0] c, input logic [1:0] p, input logic s,
                         input logic [15:0] d);
        code = c; cur = p; supv_en = s; deleg = d;
    endtask

    initial begin
        // R7 reset state, observed while reset is held
        repeat (3) @(negedge clk);
        apply(6'd2, 2'b00, 1'b1, 16'h0104);
        @(negedge clk);
        check("R7 reset", 2'b11, 1'b0, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [33:0] e;
            logic [XLEN-1:0] ev;
            e = VEC_TBL[i];
            apply(e[29:24], e[23:22], e[21], e[20:5]);
            ev = (e[1:0] == 2'd1) ? MVEC : (e[1:0] == 2'd2) ? SVEC : '0;
            @(negedge clk);
            check($sformatf("R%0d entry %0d", e[33:30], i), e[4:3], e[2], ev);
        end

        // R5: vector follows a changed vector register value
        mtvec = 32'hDEAD_0004;
        apply(6'd5, 2'b00, 1'b0, 16'h0000);
        @(negedge clk);
        check("R5 new mtvec", 2'b11, 1'b0, 32'hDEAD_0004);

        // R7: output holds the old decision until the next rising edge
        apply(6'd2, 2'b00, 1'b1, 16'h0004);
        #1;
        check("R7 latency hold", 2'b11, 1'b0, 32'hDEAD_0004);
        @(negedge clk);
        check("R7 latency update", 2'b01, 1'b0, SVEC);

        // R7: reset mid-run returns outputs to the reset state
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 mid-run reset", 2'b11, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 2'b01, 1'b0, SVEC);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule